// File: doc/BRIEF.md
# Ring Buffer Command Fetch Controller

This block walks a circular command buffer held in memory. The host advances a write pointer; the block reads from its own read pointer up to that write pointer. It cuts the span into read bursts, requests each burst over a request/grant interface, and passes the returned dwords to a downstream consumer through a valid/ready handshake. Returned dwords can be byte-swapped on the way out. Pointers are dword indices and wrap to zero at the end of the ring.

A static control word sets the following:
- the ring length, as a clamped log2 code;
- the burst ceiling;
- the byte-swap pattern, and whether the buffer lives in system memory (swapping applies only there);
- how many quadwords are consumed between read-pointer reports to host memory;
- whether those reports are suppressed;
- whether a write-pointer write also loads the read pointer from a shadow value.

The controller is a three-state machine:
- **IDLE** takes the LAUNCH transition to **REQ** when the ring is non-empty and no reload is pending. It takes the RELOAD self-transition when a reload is pending.
- **REQ** takes GRANT to **DATA** on `req_ready`.
- **DATA** takes DRAIN back to **IDLE** when the last dword of the burst is accepted.

Top module: `cmdring_fetch`

## Requirements
- R1: The ring holds 8 dwords for size codes 0 and 1, 2^(code+1) dwords for codes 2 to 22, and 2^23 dwords for any larger code. `rd_ptr` and `wr_ptr` always stay below the ring length.
- R2: `wr_ptr` takes `wptr_wdata` masked to the ring on the clock after `wptr_wr`. The ring is empty when `rd_ptr == wr_ptr`, and no request is raised from an empty ring.
- R3: The burst code values 0, 1, 2 and 3 set ceilings of 8, 16, 32 and 64 dwords. A request length is the smallest of three values: that ceiling, the dwords left before the ring end, and the dwords up to the write pointer (or up to the ring end when the write pointer lies behind).
- R4: `req_ptr` equals the read pointer at launch. `req_valid`, `req_ptr` and `req_len` stay steady until `req_ready`.
- R5: `out_valid` is high only while a granted burst is draining. `rd_ptr` advances by one (modulo the ring) for each dword accepted with `out_valid && out_ready`.
- R6: In system memory, swap code 0 passes data unchanged. Code 1 swaps the bytes within each 16-bit half, code 2 reverses all four bytes, and code 3 exchanges the 16-bit halves. Outside system memory, data is never swapped.
- R7: After every 2^(blk+1) accepted dwords (2^blk quadwords, with blk clamped to 22), a report is raised with `wb_ptr` set to the read pointer after that dword.
- R8: `wb_valid` holds until `wb_ready`. A report raised in the cycle a pending one is accepted keeps `wb_valid` high with the newer pointer.
- R9: With `cfg_no_wb` set, no report is raised, but the consumed-dword count still restarts at each interval.
- R10: With `cfg_rptr_xfer` set, a `wptr_wr` captures `rptr_shadow`. The captured value, masked to the ring, becomes the read pointer once the machine is in IDLE. A later write before that point replaces the captured value.
- R11: A synchronous reset clears both pointers, the report counter, any pending reload, any report, and the machine state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_ring_log2 | input | 6 | Ring length code |
| cfg_blk_log2 | input | 6 | Report interval, log2 of quadwords |
| cfg_swap | input | 2 | Byte-swap pattern |
| cfg_burst | input | 2 | Burst ceiling code |
| cfg_sysmem | input | 1 | Buffer is in system memory (enables swap) |
| cfg_no_wb | input | 1 | Suppress read-pointer reports |
| cfg_rptr_xfer | input | 1 | Write-pointer write also reloads read pointer |
| wptr_wr | input | 1 | Write-pointer update strobe |
| wptr_wdata | input | PTR_W (23) | New write pointer |
| rptr_shadow | input | PTR_W (23) | Shadow read-pointer value |
| rd_ptr | output | PTR_W (23) | Active read pointer |
| wr_ptr | output | PTR_W (23) | Active write pointer |
| req_valid | output | 1 | Read request pending |
| req_ready | input | 1 | Read request granted |
| req_ptr | output | PTR_W (23) | First dword index of request |
| req_len | output | LEN_W (7) | Request length in dwords |
| rsp_valid | input | 1 | Returned dword valid |
| rsp_ready | output | 1 | Returned dword taken |
| rsp_data | input | 32 | Returned dword |
| out_valid | output | 1 | Command dword valid |
| out_ready | input | 1 | Consumer ready |
| out_data | output | 32 | Command dword after swap |
| wb_valid | output | 1 | Read-pointer report pending |
| wb_ready | input | 1 | Report accepted |
| wb_ptr | output | PTR_W (23) | Reported read pointer |

## Verification
Two functions can land on the same edge: a report can complete on `wb_ready` while the dword closing the next interval is accepted. A second pair also coincides: the IDLE reload of a pending shadow value can meet a fresh write-pointer write that captures a new shadow value. A one-quadword report interval with a tiny ring, random `wb_ready` and frequent pointer writes makes both collisions routine. A behavioural model then judges every clock on pointers, report valid and pointer, request fields and swapped data.

// File: rtl/cmdring_pkg.sv
package cmdring_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_REQ  = 2'd1,
        S_DATA = 2'd2
    } fetch_state_e;

    typedef enum logic [1:0] {
        SW_NONE = 2'd0,
        SW_HALF = 2'd1,
        SW_FULL = 2'd2,
        SW_WORD = 2'd3
    } swap_mode_e;

    localparam int unsigned DWORD_W = 32;
endpackage

// File: rtl/cmdring_geom.sv
module cmdring_geom #(
    parameter int RING_LOG2_MAX = 22,
    parameter int PTR_W         = RING_LOG2_MAX + 1,
    parameter int LEN_W         = 7
) (
    input  logic [5:0]       ring_code,
    input  logic [5:0]       blk_code,
    input  logic [1:0]       burst_code,
    output logic [PTR_W-1:0] ring_mask,
    output logic [PTR_W-1:0] thr_m1,
    output logic [LEN_W-1:0] burst_max
);
    localparam logic [5:0] RMAX = 6'(RING_LOG2_MAX);

    logic [5:0] ring_eff;
    logic [5:0] blk_eff;

    always_comb begin
        if (ring_code < 6'd2)
            ring_eff = 6'd2;
        else if (ring_code > RMAX)
            ring_eff = RMAX;
        else
            ring_eff = ring_code;
        blk_eff   = (blk_code > RMAX) ? RMAX : blk_code;
        burst_max = LEN_W'(8) << burst_code;
    end

    for (genvar i = 0; i < PTR_W; i++) begin : g_mask
        assign ring_mask[i] = (6'(i) <= ring_eff);
        assign thr_m1[i]    = (6'(i) <= blk_eff);
    end
endmodule

// File: rtl/cmdring_swap.sv
module cmdring_swap
    import cmdring_pkg::*;
(
    input  logic [DWORD_W-1:0] din,
    input  logic [1:0]         mode,
    input  logic               en,
    output logic [DWORD_W-1:0] dout
);
    always_comb begin
        dout = din;
        if (en) begin
            unique case (swap_mode_e'(mode))
                SW_NONE: dout = din;
                SW_HALF: dout = {din[23:16], din[31:24], din[7:0], din[15:8]};
                SW_FULL: dout = {din[7:0], din[15:8], din[23:16], din[31:24]};
                SW_WORD: dout = {din[15:0], din[31:16]};
                default: dout = din;
            endcase
        end
    end
endmodule

// File: rtl/cmdring_wb.sv
module cmdring_wb #(
    parameter int PTR_W = 23
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic [PTR_W-1:0] new_ptr,
    input  logic [PTR_W-1:0] thr_m1,
    input  logic             suppress,
    input  logic             wb_ready,
    output logic             wb_valid,
    output logic [PTR_W-1:0] wb_ptr
);
    logic [PTR_W-1:0] cnt_q;
    logic             hit;
    logic             fire;

    assign hit  = step && (cnt_q == thr_m1);
    assign fire = hit && !suppress;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            wb_valid <= 1'b0;
            wb_ptr   <= '0;
        end else begin
            if (hit)
                cnt_q <= '0;
            else if (step)
                cnt_q <= cnt_q + PTR_W'(1);

            if (fire) begin
                wb_valid <= 1'b1;
                wb_ptr   <= new_ptr;
            end else if (wb_valid && wb_ready) begin
                wb_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cmdring_fetch.sv
module cmdring_fetch
    import cmdring_pkg::*;
#(
    parameter int RING_LOG2_MAX = 22,
    parameter int MAX_BURST_DW  = 64,
    localparam int PTR_W        = RING_LOG2_MAX + 1,
    localparam int LEN_W        = $clog2(MAX_BURST_DW + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [5:0]         cfg_ring_log2,
    input  logic [5:0]         cfg_blk_log2,
    input  logic [1:0]         cfg_swap,
    input  logic [1:0]         cfg_burst,
    input  logic               cfg_sysmem,
    input  logic               cfg_no_wb,
    input  logic               cfg_rptr_xfer,
    input  logic               wptr_wr,
    input  logic [PTR_W-1:0]   wptr_wdata,
    input  logic [PTR_W-1:0]   rptr_shadow,
    output logic [PTR_W-1:0]   rd_ptr,
    output logic [PTR_W-1:0]   wr_ptr,
    output logic               req_valid,
    input  logic               req_ready,
    output logic [PTR_W-1:0]   req_ptr,
    output logic [LEN_W-1:0]   req_len,
    input  logic               rsp_valid,
    output logic               rsp_ready,
    input  logic [DWORD_W-1:0] rsp_data,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [DWORD_W-1:0] out_data,
    output logic               wb_valid,
    input  logic               wb_ready,
    output logic [PTR_W-1:0]   wb_ptr
);
    localparam logic [PTR_W:0] ONE_W = (PTR_W+1)'(1);

    fetch_state_e     state_q, state_d;
    logic [PTR_W-1:0] rptr_q, wptr_q, shadow_q, req_ptr_q, rptr_nxt;
    logic [LEN_W-1:0] req_len_q, remain_q, launch_len;
    logic             pend_q;
    logic [PTR_W-1:0] ring_mask, thr_m1;
    logic [LEN_W-1:0] burst_max;
    logic [PTR_W:0]   to_end, avail, lim, len_wide;
    logic             launch, reload, accept;

    cmdring_geom #(
        .RING_LOG2_MAX(RING_LOG2_MAX),
        .PTR_W        (PTR_W),
        .LEN_W        (LEN_W)
    ) u_geom (
        .ring_code (cfg_ring_log2),
        .blk_code  (cfg_blk_log2),
        .burst_code(cfg_burst),
        .ring_mask (ring_mask),
        .thr_m1    (thr_m1),
        .burst_max (burst_max)
    );

    // Burst sizing: ceiling, ring end, write pointer
    always_comb begin
        to_end = {1'b0, ring_mask} - {1'b0, rptr_q} + ONE_W;
        avail  = (wptr_q > rptr_q) ? ({1'b0, wptr_q} - {1'b0, rptr_q}) : to_end;
        lim    = (avail < to_end) ? avail : to_end;
        len_wide = (lim < (PTR_W+1)'(burst_max)) ? lim : (PTR_W+1)'(burst_max);
        launch_len = LEN_W'(len_wide);
        rptr_nxt   = (rptr_q + PTR_W'(1)) & ring_mask;
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // Next state: LAUNCH, RELOAD, GRANT, DRAIN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (launch) state_d = S_REQ;
            S_REQ:  if (req_ready) state_d = S_DATA;
            S_DATA: if (accept && remain_q == LEN_W'(1)) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_valid = (state_q == S_REQ);
        out_valid = (state_q == S_DATA) && rsp_valid;
        rsp_ready = (state_q == S_DATA) && out_ready;
        accept    = out_valid && out_ready;
        reload    = (state_q == S_IDLE) && pend_q;
        launch    = (state_q == S_IDLE) && !pend_q && (rptr_q != wptr_q);
        rd_ptr    = rptr_q;
        wr_ptr    = wptr_q;
        req_ptr   = req_ptr_q;
        req_len   = req_len_q;
    end

    // Pointer and burst registers
    always_ff @(posedge clk) begin
        if (rst) begin
            rptr_q    <= '0;
            wptr_q    <= '0;
            shadow_q  <= '0;
            pend_q    <= 1'b0;
            req_ptr_q <= '0;
            req_len_q <= '0;
            remain_q  <= '0;
        end else begin
            if (reload)
                rptr_q <= shadow_q & ring_mask;
            else if (accept)
                rptr_q <= rptr_nxt;

            if (wptr_wr)
                wptr_q <= wptr_wdata & ring_mask;

            if (wptr_wr && cfg_rptr_xfer) begin
                pend_q   <= 1'b1;
                shadow_q <= rptr_shadow;
            end else if (reload) begin
                pend_q <= 1'b0;
            end

            if (launch) begin
                req_ptr_q <= rptr_q;
                req_len_q <= launch_len;
            end

            if (state_q == S_REQ && req_ready)
                remain_q <= req_len_q;
            else if (accept)
                remain_q <= remain_q - LEN_W'(1);
        end
    end

    cmdring_swap u_swap (
        .din (rsp_data),
        .mode(cfg_swap),
        .en  (cfg_sysmem),
        .dout(out_data)
    );

    cmdring_wb #(.PTR_W(PTR_W)) u_wb (
        .clk     (clk),
        .rst     (rst),
        .step    (accept),
        .new_ptr (rptr_nxt),
        .thr_m1  (thr_m1),
        .suppress(cfg_no_wb),
        .wb_ready(wb_ready),
        .wb_valid(wb_valid),
        .wb_ptr  (wb_ptr)
    );
endmodule

// File: rtl/cmdring_fetch_chk.sv
module cmdring_fetch_chk #(
    parameter int PTR_W = 23,
    parameter int LEN_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [PTR_W-1:0] req_ptr,
    input logic [LEN_W-1:0] req_len,
    input logic [LEN_W-1:0] burst_max,
    input logic [PTR_W-1:0] rd_ptr,
    input logic [PTR_W-1:0] wr_ptr,
    input logic [PTR_W-1:0] ring_mask,
    input logic             out_valid,
    input logic             out_ready,
    input logic [31:0]      out_data,
    input logic [31:0]      rsp_data,
    input logic             cfg_sysmem,
    input logic [1:0]       cfg_swap,
    input logic             wb_valid,
    input logic             wb_ready,
    input logic             cfg_no_wb
);
    AST_RPTR_IN_RING: assert property (@(posedge clk) disable iff (rst)
        (rd_ptr & ~ring_mask) == '0); // R1

    AST_EMPTY_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(req_valid) |-> $past(rd_ptr != wr_ptr)); // R2

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_len != '0) && (req_len <= burst_max)); // R3

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_ptr) && $stable(req_len)); // R4

    AST_RPTR_STEP: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready |=> rd_ptr == (($past(rd_ptr) + PTR_W'(1)) & $past(ring_mask))); // R5

    AST_SWAP_REVERSE: assert property (@(posedge clk) disable iff (rst)
        out_valid && cfg_sysmem && cfg_swap == 2'd2 |-> out_data[7:0] == rsp_data[31:24]); // R6

    AST_WB_HOLD: assert property (@(posedge clk) disable iff (rst)
        wb_valid && !wb_ready |=> wb_valid); // R8

    AST_NO_WB: assert property (@(posedge clk) disable iff (rst)
        cfg_no_wb && !wb_valid |=> !wb_valid); // R9
endmodule

bind cmdring_fetch cmdring_fetch_chk #(.PTR_W(PTR_W), .LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_ptr   (req_ptr),
    .req_len   (req_len),
    .burst_max (burst_max),
    .rd_ptr    (rd_ptr),
    .wr_ptr    (wr_ptr),
    .ring_mask (ring_mask),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .rsp_data  (rsp_data),
    .cfg_sysmem(cfg_sysmem),
    .cfg_swap  (cfg_swap),
    .wb_valid  (wb_valid),
    .wb_ready  (wb_ready),
    .cfg_no_wb (cfg_no_wb)
);

// File: tb/cmdring_fetch_tb.sv
module cmdring_fetch_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PTR_W      = 23;
    localparam int LEN_W      = 7;
    localparam int PHASE_CYC  = 5000;
    localparam int WATCHDOG   = 100000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [5:0]       cfg_ring_log2 = '0, cfg_blk_log2 = '0;
    logic [1:0]       cfg_swap = '0, cfg_burst = '0;
    logic             cfg_sysmem = 1'b0, cfg_no_wb = 1'b0, cfg_rptr_xfer = 1'b0;
    logic             wptr_wr = 1'b0;
    logic [PTR_W-1:0] wptr_wdata = '0, rptr_shadow = '0;
    logic [PTR_W-1:0] rd_ptr, wr_ptr, req_ptr, wb_ptr;
    logic [LEN_W-1:0] req_len;
    logic             req_valid, req_ready = 1'b0;
    logic             rsp_valid = 1'b0, rsp_ready;
    logic [31:0]      rsp_data = '0, out_data;
    logic             out_valid, out_ready = 1'b0;
    logic             wb_valid, wb_ready = 1'b0;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // reference model state
    int m_state = 0, m_rptr = 0, m_wptr = 0, m_shadow = 0, m_len = 0, m_rem = 0, m_cnt = 0, m_wbp = 0;
    bit m_pend = 0, m_wbv = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmdring_fetch u_dut (.*);

    function automatic int ring_words(input logic [5:0] c);
        int e;
        e = (c < 2) ? 2 : ((c > 22) ? 22 : int'(c));
        return 1 << (e + 1);
    endfunction

    function automatic int wb_thr(input logic [5:0] c);
        int e;
        e = (c > 22) ? 22 : int'(c);
        return 1 << (e + 1);
    endfunction

    function automatic int exp_len(input int rp, input int wp, input int rw, input logic [1:0] b);
        int to_end, avail, len;
        to_end = rw - rp;
        avail  = (wp > rp) ? (wp - rp) : to_end;
        len    = 8 << b;
        if (to_end < len) len = to_end;
        if (avail < len) len = avail;
        return len;
    endfunction

    function automatic logic [31:0] ref_swap(input logic [31:0] d, input logic [1:0] m, input logic sys);
        logic [7:0] b0, b1, b2, b3;
        b0 = d[7:0]; b1 = d[15:8]; b2 = d[23:16]; b3 = d[31:24];
        if (!sys) return d;
        case (m)
            2'd1:    return {b2, b3, b0, b1};
            2'd2:    return {b0, b1, b2, b3};
            2'd3:    return {b1, b0, b3, b2};
            default: return d;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle-level behavioural model
    always @(posedge clk) begin
        int rw;
        bit wbv_n;
        rw = ring_words(cfg_ring_log2);
        if (rst) begin
            m_state = 0; m_rptr = 0; m_wptr = 0; m_shadow = 0; m_len = 0;
            m_rem = 0; m_cnt = 0; m_wbp = 0; m_pend = 0; m_wbv = 0;
        end else begin
            wbv_n = m_wbv;
            if (m_wbv && wb_ready) wbv_n = 0;
            case (m_state)
                0: begin
                    if (m_pend) begin
                        m_rptr = m_shadow & (rw - 1);
                        m_pend = 0;
                    end else if (m_rptr != m_wptr) begin
                        m_len = exp_len(m_rptr, m_wptr, rw, cfg_burst);
                        m_state = 1;
                    end
                end
                1: if (req_ready) begin
                    m_state = 2;
                    m_rem = m_len;
                end
                default: if (rsp_valid && out_ready) begin
                    m_rptr = (m_rptr + 1) & (rw - 1);
                    m_cnt++;
                    if (m_cnt == wb_thr(cfg_blk_log2)) begin
                        m_cnt = 0;
                        if (!cfg_no_wb) begin
                            wbv_n = 1;
                            m_wbp = m_rptr;
                        end
                    end
                    m_rem--;
                    if (m_rem == 0) m_state = 0;
                end
            endcase
            m_wbv = wbv_n;
            if (wptr_wr) begin
                m_wptr = int'(wptr_wdata) & (rw - 1);
                if (cfg_rptr_xfer) begin
                    m_pend = 1;
                    m_shadow = int'(rptr_shadow);
                end
            end
        end
    end

    task automatic compare_all();
        chk(rd_ptr == PTR_W'(m_rptr), "R5 R10 rd_ptr", rd_ptr, m_rptr);
        chk(int'(rd_ptr) < ring_words(cfg_ring_log2), "R1 rd_ptr range", rd_ptr, ring_words(cfg_ring_log2));
        chk(wr_ptr == PTR_W'(m_wptr), "R2 wr_ptr", wr_ptr, m_wptr);
        chk(req_valid == (m_state == 1), "R2 req_valid", req_valid, m_state == 1);
        if (m_state == 1) begin
            chk(req_ptr == PTR_W'(m_rptr), "R4 req_ptr", req_ptr, m_rptr);
            chk(req_len == LEN_W'(m_len), "R3 req_len", req_len, m_len);
        end
        chk(out_valid == (rsp_valid && m_state == 2), "R5 out_valid", out_valid, rsp_valid && m_state == 2);
        if (out_valid)
            chk(out_data == ref_swap(rsp_data, cfg_swap, cfg_sysmem), "R6 out_data",
                out_data, ref_swap(rsp_data, cfg_swap, cfg_sysmem));
        chk(wb_valid == m_wbv, "R8 wb_valid", wb_valid, m_wbv);
        if (m_wbv)
            chk(wb_ptr == PTR_W'(m_wbp), "R7 wb_ptr", wb_ptr, m_wbp);
        if (cfg_no_wb && !rst)
            chk(!wb_valid, "R9 suppressed", wb_valid, 0);
    endtask

    task automatic run_phase(input logic [5:0] ring, input logic [5:0] blk, input logic [1:0] burst,
                             input logic [1:0] sw, input logic sys, input logic nowb, input logic xfer);
        @(negedge clk);
        rst = 1'b1;
        wptr_wr = 1'b0; req_ready = 1'b0; rsp_valid = 1'b0; out_ready = 1'b0; wb_ready = 1'b0;
        cfg_ring_log2 = ring; cfg_blk_log2 = blk; cfg_burst = burst;
        cfg_swap = sw; cfg_sysmem = sys; cfg_no_wb = nowb; cfg_rptr_xfer = xfer;
        repeat (3) @(negedge clk);
        chk(rd_ptr == '0 && wr_ptr == '0, "R11 pointers cleared", rd_ptr, 0);
        chk(!req_valid && !wb_valid && !out_valid, "R11 idle outputs", {req_valid, wb_valid, out_valid}, 0);
        rst = 1'b0;
        for (int c = 0; c < PHASE_CYC; c++) begin
            @(negedge clk);
            compare_all();
            req_ready = ($urandom % 3) != 0;
            rsp_valid = ($urandom % 4) != 0;
            out_ready = ($urandom % 4) != 0;
            wb_ready  = ($urandom % 2) != 0;
            rsp_data  = $urandom;
            wptr_wr   = ($urandom % 12) == 0;
            if (($urandom % 8) == 0)
                wptr_wdata = PTR_W'($urandom);
            else
                wptr_wdata = PTR_W'(m_rptr + int'($urandom_range(0, 80)));
            rptr_shadow = PTR_W'($urandom_range(0, 300));
        end
    endtask

    initial begin
        run_phase(6'd0,  6'd0,  2'd0, 2'd1, 1'b1, 1'b0, 1'b0);
        run_phase(6'd30, 6'd3,  2'd3, 2'd2, 1'b0, 1'b0, 1'b0);
        run_phase(6'd4,  6'd1,  2'd2, 2'd3, 1'b1, 1'b1, 1'b1);
        run_phase(6'd1,  6'd40, 2'd1, 2'd2, 1'b1, 1'b0, 1'b1);
        run_phase(6'd3,  6'd0,  2'd2, 2'd0, 1'b1, 1'b0, 1'b1);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule